// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

This block caches virtual-to-physical page translations in 64 entries arranged as 32 sets of two ways. A lookup presents a virtual page number. One clock later the block reports either a hit, together with the physical page number and the protection bits stored with it, or a miss. On a miss the block keeps the faulting virtual page number so that a software-assisted search of the hashed page table can run. That search later installs the translation through the refill port.

The refill port picks its own way. If the page is already present in the set, that way is rewritten. Otherwise the first empty way is used. When both ways are full, the least recently used way is replaced. Supervisor code can clear one whole set through the invalidate port. A clear request without the supervisor qualifier is ignored.

Top module: `xlat_buf`

## Requirements
- R1: After reset every entry is invalid and the lookup outputs are low, so any lookup misses.
- R2: The set index is virtual page number bits [4:0] and the tag is the remaining upper bits. A lookup with `lk_valid` high whose tag matches a valid way of its set raises `lk_hit` one cycle later, with that way's physical page number on `lk_ppn` and its protection bits on `lk_prot`.
- R3: A lookup that matches no valid way raises `lk_miss` one cycle later, with `lk_hit`, `lk_ppn` and `lk_prot` all zero. `miss_vpn` then shows the looked-up virtual page number and holds it until the next miss.
- R4: In the cycle after `lk_valid` is low, both `lk_hit` and `lk_miss` are low.
- R5: A refill into a set with an empty way uses way 0 first and then way 1, so two distinct pages refilled into one set both hit afterwards.
- R6: When both ways are valid, a refill replaces the least recently used way. A lookup hit and a refill each mark the way they touch as most recently used.
- R7: Refilling a page whose tag already sits in the set rewrites that way and leaves the other way untouched.
- R8: An invalidate with `inv_sup` high clears both ways of set `inv_idx` and leaves every other set unchanged.
- R9: An invalidate with `inv_sup` low has no effect.
- R10: A lookup sees the contents from before a refill in the same cycle. When a refill and a supervisor invalidate target the same set in one cycle, the invalidate wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | Registered hit result |
| lk_miss | output | 1 | Registered miss result |
| lk_ppn | output | 20 | Physical page number on hit |
| lk_prot | output | 4 | Protection bits on hit |
| miss_vpn | output | 20 | Virtual page number of the latest miss |
| fill_en | input | 1 | Refill request |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_prot | input | 4 | Protection bits to install |
| inv_en | input | 1 | Set invalidate request |
| inv_sup | input | 1 | Supervisor qualifier for invalidate |
| inv_idx | input | 5 | Set to invalidate |

## Verification
The hardest state to reach is a full set whose replacement bit no longer points at the way the refill order would suggest. To reach it, the bench fills both ways of one set, hits the older page so that the newer one becomes least recently used, and then refills a third page. It then checks which of the two earlier pages survived. Same-cycle collisions are driven in a single cycle: a refill together with a lookup, and a refill together with a supervisor clear of the same set. Each order is then checked at the lookup port.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    parameter int VPN_W  = 20;
    parameter int PPN_W  = 20;
    parameter int PROT_W = 4;
    parameter int SETS   = 32;
    parameter int WAYS   = 2;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [PROT_W-1:0] prot;
    } entry_t;

    typedef entry_t [WAYS-1:0] set_t;

    typedef struct packed {
        set_t [SETS-1:0]   ent;
        logic [SETS-1:0]   lru;      // points at least recently used way
        logic              hit;
        logic              miss;
        logic [PPN_W-1:0]  ppn;
        logic [PROT_W-1:0] prot;
        logic [VPN_W-1:0]  miss_vpn;
    } state_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
(
    input  set_t             set_in,
    input  logic [TAG_W-1:0] tag,
    output logic [WAYS-1:0]  match
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = set_in[w].vld && (set_in[w].tag == tag);
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
(
    input  set_t            set_in,
    input  logic [WAYS-1:0] match,
    input  logic            lru,
    output logic            way
);
    always_comb begin
        if (|match)              way = match[1];
        else if (!set_in[0].vld) way = 1'b0;
        else if (!set_in[1].vld) way = 1'b1;
        else                     way = lru;
    end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PROT_W-1:0] lk_prot,
    output logic [VPN_W-1:0]  miss_vpn,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              inv_en,
    input  logic              inv_sup,
    input  logic [IDX_W-1:0]  inv_idx
);
    state_t state_d, state_q;

    logic [IDX_W-1:0] lk_idx, fill_idx;
    logic [TAG_W-1:0] lk_tag, fill_tag;
    logic [WAYS-1:0]  lk_match, fill_match;
    logic             fill_way;

    assign lk_idx   = lk_vpn[IDX_W-1:0];
    assign lk_tag   = lk_vpn[VPN_W-1:IDX_W];
    assign fill_idx = fill_vpn[IDX_W-1:0];
    assign fill_tag = fill_vpn[VPN_W-1:IDX_W];

    xlat_match u_lk_match (
        .set_in (state_q.ent[lk_idx]),
        .tag    (lk_tag),
        .match  (lk_match)
    );

    xlat_match u_fill_match (
        .set_in (state_q.ent[fill_idx]),
        .tag    (fill_tag),
        .match  (fill_match)
    );

    xlat_victim u_victim (
        .set_in (state_q.ent[fill_idx]),
        .match  (fill_match),
        .lru    (state_q.lru[fill_idx]),
        .way    (fill_way)
    );

    always_comb begin
        state_d      = state_q;
        state_d.hit  = 1'b0;
        state_d.miss = 1'b0;
        state_d.ppn  = '0;
        state_d.prot = '0;
        if (lk_valid) begin
            if (|lk_match) begin
                state_d.hit  = 1'b1;
                state_d.ppn  = state_q.ent[lk_idx][lk_match[1]].ppn;
                state_d.prot = state_q.ent[lk_idx][lk_match[1]].prot;
                state_d.lru[lk_idx] = ~lk_match[1];
            end else begin
                state_d.miss     = 1'b1;
                state_d.miss_vpn = lk_vpn;
            end
        end
        if (fill_en) begin
            state_d.ent[fill_idx][fill_way].vld  = 1'b1;
            state_d.ent[fill_idx][fill_way].tag  = fill_tag;
            state_d.ent[fill_idx][fill_way].ppn  = fill_ppn;
            state_d.ent[fill_idx][fill_way].prot = fill_prot;
            state_d.lru[fill_idx] = ~fill_way;
        end
        if (inv_en && inv_sup) begin
            state_d.ent[inv_idx][0].vld = 1'b0;
            state_d.ent[inv_idx][1].vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign lk_hit   = state_q.hit;
    assign lk_miss  = state_q.miss;
    assign lk_ppn   = state_q.ppn;
    assign lk_prot  = state_q.prot;
    assign miss_vpn = state_q.miss_vpn;

    // R2
    one_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!lk_hit && !lk_miss));
    // R3
    hit_xor_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (lk_hit ^ lk_miss));
    // R3
    miss_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!lk_miss || miss_vpn == $past(lk_vpn)));
    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_ppn == '0 && lk_prot == '0));
    // R8
    inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && inv_sup) |=> (!state_q.ent[$past(inv_idx)][0].vld &&
                                 !state_q.ent[$past(inv_idx)][1].vld));
endmodule

// File: tb/sim_xlat_buf.sv
module sim_xlat_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit, lk_miss;
    logic [19:0] lk_ppn;
    logic [3:0]  lk_prot;
    logic [19:0] miss_vpn;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [3:0]  fill_prot = '0;
    logic        inv_en = 1'b0;
    logic        inv_sup = 1'b0;
    logic [4:0]  inv_idx = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xlat_buf u0 (.*);

    function automatic logic [19:0] mk(input int tag, input int idx);
        return {tag[14:0], idx[4:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] pr);
        fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_prot = pr;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic look(input string req, input logic [19:0] v,
                        input bit exp_hit, input logic [19:0] exp_ppn, input logic [3:0] exp_prot);
        lk_valid = 1'b1; lk_vpn = v;
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, lk_hit, exp_hit);
        check(req, lk_miss, !exp_hit);
        check(req, lk_ppn, exp_hit ? exp_ppn : 20'h0);
        check(req, lk_prot, exp_hit ? exp_prot : 4'h0);
        if (!exp_hit) check(req, miss_vpn, v);
    endtask

    task automatic inv(input logic [4:0] idx, input bit sup);
        inv_en = 1'b1; inv_sup = sup; inv_idx = idx;
        @(negedge clk);
        inv_en = 1'b0; inv_sup = 1'b0;
    endtask

    task automatic t_reset();
        // R1
        check("R1", lk_hit, 0);
        check("R1", lk_miss, 0);
        look("R1", mk(0, 0), 0, 0, 0);
        look("R1", mk(7, 31), 0, 0, 0);
    endtask

    task automatic t_basic();
        // R2 R3 R4 R5
        fill(mk(5, 3), 20'hAAAA1, 4'h3);
        look("R2", mk(5, 3), 1, 20'hAAAA1, 4'h3);
        look("R3", mk(5, 4), 0, 0, 0);
        look("R3", mk(6, 3), 0, 0, 0);
        @(negedge clk);
        check("R4", lk_hit, 0);
        check("R4", lk_miss, 0);
        check("R3", miss_vpn, mk(6, 3));
        look("R2", mk(5, 3), 1, 20'hAAAA1, 4'h3);
        check("R3", miss_vpn, mk(6, 3));
        fill(mk(9, 3), 20'hBBBB2, 4'h5);
        look("R5", mk(5, 3), 1, 20'hAAAA1, 4'h3);
        look("R5", mk(9, 3), 1, 20'hBBBB2, 4'h5);
    endtask

    task automatic t_lru();
        // R6
        fill(mk(1, 10), 20'h00101, 4'h1);
        fill(mk(2, 10), 20'h00202, 4'h2);
        look("R6", mk(1, 10), 1, 20'h00101, 4'h1);
        fill(mk(3, 10), 20'h00303, 4'h4);
        look("R6", mk(2, 10), 0, 0, 0);
        look("R6", mk(1, 10), 1, 20'h00101, 4'h1);
        look("R6", mk(3, 10), 1, 20'h00303, 4'h4);
        fill(mk(4, 10), 20'h00404, 4'h8);
        look("R6", mk(1, 10), 0, 0, 0);
        look("R6", mk(3, 10), 1, 20'h00303, 4'h4);
    endtask

    task automatic t_rewrite();
        // R7
        fill(mk(11, 12), 20'h11111, 4'h1);
        fill(mk(12, 12), 20'h22222, 4'h2);
        fill(mk(11, 12), 20'h33333, 4'h7);
        look("R7", mk(11, 12), 1, 20'h33333, 4'h7);
        look("R7", mk(12, 12), 1, 20'h22222, 4'h2);
    endtask

    task automatic t_inval();
        // R8 R9
        fill(mk(20, 20), 20'h0A0A0, 4'h6);
        fill(mk(21, 20), 20'h0B0B0, 4'h9);
        fill(mk(20, 21), 20'h0C0C0, 4'hC);
        inv(5'd20, 1'b0);
        look("R9", mk(20, 20), 1, 20'h0A0A0, 4'h6);
        look("R9", mk(21, 20), 1, 20'h0B0B0, 4'h9);
        inv(5'd20, 1'b1);
        look("R8", mk(20, 20), 0, 0, 0);
        look("R8", mk(21, 20), 0, 0, 0);
        look("R8", mk(20, 21), 1, 20'h0C0C0, 4'hC);
    endtask

    task automatic t_collide();
        // R10
        fill(mk(30, 25), 20'h0D0D0, 4'hD);
        lk_valid = 1'b1; lk_vpn = mk(31, 25);
        fill_en = 1'b1; fill_vpn = mk(31, 25); fill_ppn = 20'h0E0E0; fill_prot = 4'hE;
        @(negedge clk);
        lk_valid = 1'b0; fill_en = 1'b0;
        check("R10", lk_miss, 1);
        look("R10", mk(31, 25), 1, 20'h0E0E0, 4'hE);
        fill_en = 1'b1; fill_vpn = mk(32, 26); fill_ppn = 20'h0F0F0; fill_prot = 4'hF;
        inv_en = 1'b1; inv_sup = 1'b1; inv_idx = 5'd26;
        @(negedge clk);
        fill_en = 1'b0; inv_en = 1'b0; inv_sup = 1'b0;
        look("R10", mk(32, 26), 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_lru();
        t_rewrite();
        t_inval();
        t_collide();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule